// File: doc/BRIEF.md
# Three-Level Gated Interrupt Controller

This block gathers interrupt flags from a set of peripheral modules and decides whether to raise one interrupt request to a processor core. Every flag must pass three gates before it can reach the core. The first is its own local enable. The second is a mask bit for the group the flag belongs to, and all of these mask bits live in one register. The third is a single global enable. Because the group masks share one register, one write can enable or silence sources spread over several modules at once.

To find the pending source, software first reads a group identification register, which has one bit per group. It then reads that group's module identification register, which shows which module in the group is pending. It finishes by reading the module's flag register. One group also carries four software interrupt flags. These have no local enable and appear only at group level. The block reports the lowest-numbered pending, unmasked group as a vector index. An acknowledge input drops the global enable so that the handler runs without nesting.

Top module: `hier_irq_ctrl`

## Requirements
- R1: `irq_o` is 1 only when some flag of a module is set with its local enable bit set (module m enable register at 0x30+m, bit n enables flag n), the mask bit of that module's group is set, and the global enable is 1.
- R2: After reset, the global enable (register 0x00, bit 0), the mask, all flags, all local enables, the software flags, `irq_o` and `irq_vec_o` are all 0.
- R3: The mask register (0x01) holds one bit per group, with bit g for group g. One write changes the masking of all groups together.
- R4: Bit g of the group identification register (0x02, read-only) is 1 when any enabled flag in group g is set. This bit does not depend on the mask or the global enable.
- R5: Bit k of the module identification register of group g (0x08+g, read-only) is 1 when module g*2+k has an enabled flag set. Software flags never appear in these registers.
- R6: Module flags (0x20+m) are sticky. An event pulse sets a flag. Writing 0 to a flag's bit clears it, and writing 1 leaves it unchanged. An event arriving in the same cycle as a clearing write leaves the flag set.
- R7: The software flag register (0x03, bits 3:0) is read/write. Any set bit makes group 3 pending with no local enable, subject only to mask bit 3 and the global enable.
- R8: `irq_vec_o` gives the lowest-numbered group that is both pending and unmasked, or 0 when there is none.
- R9: When `ack_i` is 1, the global enable reads 0 from the next cycle. `ack_i` takes priority over a write of register 0x00 in the same cycle.
- R10: `irq_o` and `irq_vec_o` are registered and follow a flag, enable or mask change one clock later. `reg_rdata` returns the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 40 | One-cycle event pulses; bits 4m+3:4m belong to module m |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| irq_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | 3 | Registered index of the lowest pending unmasked group |

## Verification
The hardest case to reach from the ports is a collision in a single cycle. This happens when an event lands on the same flag bit that a clearing write targets, or when an acknowledge meets a write that sets the global enable. Directed steps arrange both collisions on purpose. After that, thousands of random cycles mix sparse event pulses with writes to enables, flag clears, masks and software flags, together with acknowledges that follow the request. A bench model compares the request, the vector and every read on every cycle.

// File: rtl/hic_pkg.sv
package hic_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'h01;
  localparam logic [ADDR_W-1:0] A_TOPID = 6'h02;
  localparam logic [ADDR_W-1:0] A_SWF   = 6'h03;
  localparam logic [ADDR_W-1:0] A_SUB   = 6'h08;
  localparam logic [ADDR_W-1:0] A_FLG   = 6'h20;
  localparam logic [ADDR_W-1:0] A_ENA   = 6'h30;
endpackage

// File: rtl/hic_src_bank.sv
module hic_src_bank #(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] evt,
  input  logic              flg_we,
  input  logic              en_we,
  input  logic [FLAG_W-1:0] wdata,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] en_o,
  output logic              pend_o
);
  logic [FLAG_W-1:0] flags_q, en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      flags_q <= (flg_we ? (flags_q & wdata) : flags_q) | evt;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign pend_o  = |(flags_q & en_q);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags_q & $past(evt)) == $past(evt))); // R6
  AST_NO_WRITE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !flg_we |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R6
endmodule

// File: rtl/hic_merge.sv
module hic_merge #(
  parameter int N_GRP  = 5,
  parameter int MPG    = 2,
  parameter int SW_GRP = 3,
  parameter int SW_N   = 4,
  localparam int N_MOD = N_GRP * MPG,
  localparam int GID_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic [N_MOD-1:0] mod_pend,
  input  logic [SW_N-1:0]  sw_flags,
  input  logic [N_GRP-1:0] mask,
  output logic [N_GRP-1:0] top_id,
  output logic             any_hit,
  output logic [GID_W-1:0] sel_idx
);
  logic [N_GRP-1:0] hit;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    if (g == SW_GRP) begin : g_sw
      assign top_id[g] = (|mod_pend[g*MPG +: MPG]) | (|sw_flags);
    end else begin : g_hw
      assign top_id[g] = |mod_pend[g*MPG +: MPG];
    end
  end

  assign hit     = top_id & mask;
  assign any_hit = |hit;

  always_comb begin
    sel_idx = '0;
    for (int g = N_GRP - 1; g >= 0; g--) begin
      if (hit[g]) sel_idx = GID_W'(g);
    end
  end
endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
  import hic_pkg::*;
#(
  parameter int N_GRP  = 5,
  parameter int MPG    = 2,
  parameter int FLAG_W = 4,
  parameter int SW_GRP = 3,
  parameter int SW_N   = 4,
  localparam int N_MOD = N_GRP * MPG,
  localparam int GID_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MOD*FLAG_W-1:0] evt_i,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    ack_i,
  output logic                    irq_o,
  output logic [GID_W-1:0]        irq_vec_o
);
  logic             ge_q;
  logic [N_GRP-1:0] mask_q;
  logic [SW_N-1:0]  sw_q;
  logic             irq_q;
  logic [GID_W-1:0] vec_q;
  logic [DATA_W-1:0] rd_q, rd_n;

  logic [FLAG_W-1:0] flg_a [N_MOD];
  logic [FLAG_W-1:0] ena_a [N_MOD];
  logic [N_MOD-1:0]  mod_pend;
  logic [N_GRP-1:0]  top_id;
  logic              any_hit;
  logic [GID_W-1:0]  sel_idx;

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    logic flg_we, en_we;
    assign flg_we = reg_we && (reg_addr == A_FLG + ADDR_W'(m));
    assign en_we  = reg_we && (reg_addr == A_ENA + ADDR_W'(m));
    hic_src_bank #(.FLAG_W(FLAG_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_i[m*FLAG_W +: FLAG_W]),
      .flg_we  (flg_we),
      .en_we   (en_we),
      .wdata   (reg_wdata[FLAG_W-1:0]),
      .flags_o (flg_a[m]),
      .en_o    (ena_a[m]),
      .pend_o  (mod_pend[m])
    );
  end

  hic_merge #(.N_GRP(N_GRP), .MPG(MPG), .SW_GRP(SW_GRP), .SW_N(SW_N)) u_merge (
    .mod_pend (mod_pend),
    .sw_flags (sw_q),
    .mask     (mask_q),
    .top_id   (top_id),
    .any_hit  (any_hit),
    .sel_idx  (sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ge_q   <= 1'b0;
      mask_q <= '0;
      sw_q   <= '0;
      irq_q  <= 1'b0;
      vec_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (ack_i) ge_q <= 1'b0;
      else if (reg_we && reg_addr == A_CTRL) ge_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[N_GRP-1:0];
      if (reg_we && reg_addr == A_SWF)  sw_q   <= reg_wdata[SW_N-1:0];
      irq_q <= ge_q & any_hit;
      vec_q <= sel_idx;
      rd_q  <= rd_n;
    end
  end

  always_comb begin
    rd_n = '0;
    if (reg_addr == A_CTRL)  rd_n[0] = ge_q;
    if (reg_addr == A_MASK)  rd_n[N_GRP-1:0] = mask_q;
    if (reg_addr == A_TOPID) rd_n[N_GRP-1:0] = top_id;
    if (reg_addr == A_SWF)   rd_n[SW_N-1:0] = sw_q;
    for (int g = 0; g < N_GRP; g++) begin
      if (reg_addr == A_SUB + ADDR_W'(g)) rd_n[MPG-1:0] = mod_pend[g*MPG +: MPG];
    end
    for (int m = 0; m < N_MOD; m++) begin
      if (reg_addr == A_FLG + ADDR_W'(m)) rd_n[FLAG_W-1:0] = flg_a[m];
      if (reg_addr == A_ENA + ADDR_W'(m)) rd_n[FLAG_W-1:0] = ena_a[m];
    end
  end

  assign reg_rdata = rd_q;
  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  AST_IRQ_NEEDS_GE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ge_q)); // R1
  AST_IRQ_NEEDS_MASKED_SRC: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|(top_id & mask_q))); // R1
  AST_ACK_DROPS_GE: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !ge_q); // R9
  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (($past(top_id & mask_q) & ((N_GRP'(1) << vec_q) - N_GRP'(1))) == '0)); // R8
endmodule

// File: tb/hier_irq_ctrl_bench.sv
module hier_irq_ctrl_bench;
  localparam int NG = 5, MP = 2, FW = 4, NM = 10, EW = 40;

  logic clk = 0, rst = 1;
  logic [EW-1:0] evt = '0;
  logic we = 0, ack = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  logic [2:0] vec;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [FW-1:0] m_flg [NM];
  logic [FW-1:0] m_en  [NM];
  logic [3:0] m_sw;
  logic [NG-1:0] m_mask;
  logic m_ge;
  logic e_irq;
  logic [2:0] e_vec;
  logic [7:0] e_rd;

  always #5 clk = ~clk;

  hier_irq_ctrl u_hier_irq_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .ack_i(ack), .irq_o(irq), .irq_vec_o(vec)
  );

  function automatic logic [NG-1:0] f_top();
    logic [NG-1:0] t;
    for (int g = 0; g < NG; g++)
      t[g] = (|(m_flg[2*g] & m_en[2*g])) | (|(m_flg[2*g+1] & m_en[2*g+1])) |
             ((g == 3) && (|m_sw));
    return t;
  endfunction

  function automatic logic [2:0] f_vec();
    logic [NG-1:0] h = f_top() & m_mask;
    for (int g = 0; g < NG; g++) if (h[g]) return 3'(g);
    return 3'd0;
  endfunction

  function automatic logic [7:0] f_rd(input logic [5:0] a);
    logic [NG-1:0] t = f_top();
    logic [7:0] r = '0;
    if (a == 6'h00) r[0] = m_ge;
    if (a == 6'h01) r[NG-1:0] = m_mask;
    if (a == 6'h02) r[NG-1:0] = t;
    if (a == 6'h03) r[3:0] = m_sw;
    for (int g = 0; g < NG; g++)
      if (a == 6'h08 + 6'(g)) begin
        r[0] = |(m_flg[2*g] & m_en[2*g]);
        r[1] = |(m_flg[2*g+1] & m_en[2*g+1]);
      end
    for (int m = 0; m < NM; m++) begin
      if (a == 6'h20 + 6'(m)) r[3:0] = m_flg[m];
      if (a == 6'h30 + 6'(m)) r[3:0] = m_en[m];
    end
    return r;
  endfunction

  function automatic string f_tag(input logic [5:0] a);
    if (a == 6'h00) return "R2";
    if (a == 6'h01) return "R3";
    if (a == 6'h02) return "R4";
    if (a == 6'h03) return "R7";
    if (a >= 6'h08 && a < 6'h10) return "R5";
    if (a >= 6'h20 && a < 6'h30) return "R6";
    return "R1";
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // called at a falling edge; drives inputs, models one rising edge, checks at next falling edge
  task automatic step(input logic w, input logic [5:0] a, input logic [7:0] d,
                      input logic [EW-1:0] e, input logic k, input string tag);
    logic [5:0] ra;
    we = w; addr = a; wdata = d; evt = e; ack = k;
    ra = a;
    e_irq = m_ge && (|(f_top() & m_mask));
    e_vec = f_vec();
    e_rd  = f_rd(a);
    for (int m = 0; m < NM; m++) begin
      if (w && a == 6'h20 + 6'(m)) m_flg[m] = m_flg[m] & d[3:0];
      m_flg[m] = m_flg[m] | e[m*FW +: FW];
      if (w && a == 6'h30 + 6'(m)) m_en[m] = d[3:0];
    end
    if (w && a == 6'h03) m_sw = d[3:0];
    if (w && a == 6'h01) m_mask = d[NG-1:0];
    if (k) m_ge = 1'b0;
    else if (w && a == 6'h00) m_ge = d[0];
    @(posedge clk);
    @(negedge clk);
    check(tag, "irq", {7'b0, irq}, {7'b0, e_irq});
    check("R8", "vec", {5'b0, vec}, {5'b0, e_vec});
    check(f_tag(ra), "rdata", rdata, e_rd);
  endtask

  function automatic logic [EW-1:0] ev(input int m, input int b);
    logic [EW-1:0] x = '0;
    x[m*FW + b] = 1'b1;
    return x;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4321);
    for (int m = 0; m < NM; m++) begin m_flg[m] = '0; m_en[m] = '0; end
    m_sw = '0; m_mask = '0; m_ge = 1'b0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R2: reset state
    check("R2", "irq after reset", {7'b0, irq}, 8'h0);
    check("R2", "vec after reset", {5'b0, vec}, 8'h0);
    step(0, 6'h00, 0, '0, 0, "R2");
    step(0, 6'h30, 0, '0, 0, "R2");
    // R1: gates
    step(1, 6'h30, 8'h0F, '0, 0, "R1");
    step(0, 6'h02, 0, ev(0, 0), 0, "R1");
    step(0, 6'h02, 0, '0, 0, "R4");         // pending seen with mask and ge clear
    step(1, 6'h01, 8'h1F, '0, 0, "R3");
    step(1, 6'h00, 8'h01, '0, 0, "R1");
    step(0, 6'h08, 0, '0, 0, "R10");        // irq rises one clock after ge
    step(0, 6'h00, 0, '0, 1, "R9");
    step(0, 6'h00, 0, '0, 0, "R9");
    // R6: clear vs event collision, then plain clear
    step(1, 6'h20, 8'h00, ev(0, 0), 0, "R6");
    step(0, 6'h20, 0, '0, 0, "R6");
    step(1, 6'h20, 8'h0E, '0, 0, "R6");
    step(0, 6'h20, 0, '0, 0, "R6");
    // R7: software flags with no local enable
    step(1, 6'h03, 8'h02, '0, 0, "R7");
    step(1, 6'h00, 8'h01, '0, 0, "R7");
    step(0, 6'h0B, 0, '0, 0, "R5");
    step(0, 6'h02, 0, '0, 0, "R7");
    // R8: priority among groups 2, 3 and 4
    step(1, 6'h38, 8'h04, '0, 0, "R8");
    step(1, 6'h34, 8'h01, ev(8, 2), 0, "R8");
    step(0, 6'h0C, 0, ev(4, 0), 0, "R8");
    step(0, 6'h0A, 0, '0, 0, "R8");
    step(1, 6'h01, 8'h1B, '0, 0, "R3");     // one write masks group 2 only
    step(1, 6'h01, 8'h10, '0, 0, "R3");
    step(0, 6'h02, 0, '0, 0, "R4");
    // R9: ack beats a write of the control register
    step(1, 6'h00, 8'h01, '0, 1, "R9");
    step(0, 6'h00, 0, '0, 0, "R9");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 100;
      logic [EW-1:0] e = EW'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      logic k = e_irq && ($urandom % 4 == 0);
      int m = $urandom % NM;
      logic [7:0] d = 8'($urandom);
      if (r < 15)      step(1, 6'h30 + 6'(m), d, e, k, "R1");
      else if (r < 27) step(1, 6'h20 + 6'(m), d | 8'($urandom), e, k, "R6");
      else if (r < 33) step(1, 6'h01, d, e, k, "R3");
      else if (r < 40) step(1, 6'h00, 8'h01, e, k, "R9");
      else if (r < 44) step(1, 6'h03, d & 8'($urandom), e, k, "R7");
      else begin
        int s = $urandom % 6;
        logic [5:0] a = (s == 0) ? 6'h08 + 6'($urandom % NG) :
                        (s == 1) ? 6'h20 + 6'(m) :
                        (s == 2) ? 6'h30 + 6'(m) : 6'($urandom % 4);
        step(0, a, 0, e, k, "R10");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule